// File: doc/BRIEF.md
# Multi-Channel Compare PWM Timer

This unit derives several pulse-width-modulated outputs from one shared 16-bit counter. A power-of-two prescaler decides how often the counter moves. The counter either climbs from zero to a modulo limit and wraps, or it climbs to the limit and then descends back to zero. Each channel compares the counter against its own compare value. It drives a pin whose polarity is programmable. An even/odd channel pair can also be joined so that the even compare value sets the turn-on point and the odd compare value sets the turn-off point.

Software programs the unit through a single-cycle write port and a combinational read port. Modulo and compare writes are held in shadow registers and are copied into the working registers only at a period boundary. A channel control write reaches the working control field one clock after the write, and the read port shows that working field. Software must therefore clear a channel and see zero read back before it installs a new nonzero setting.

Address map (NCH = 4): 0 = global control (bits [2:0] prescale exponent, bit 3 up/down select, bit 4 decode-hold), 1 = modulo, 2 = pair-join bits (bit p joins channels 2p and 2p+1), 4+2i = channel i control, 5+2i = channel i compare.

Top module: `pwm_timer`

## Requirements
- R1: After reset the counter reads 0, every pin is 0, and the global and channel control registers read back 0.
- R2: The counter changes state once every 2^PS clocks, where PS is global control bits [2:0]. It holds its value between those steps.
- R3: With global control bit 3 clear, the counter steps 0, 1, …, MOD and then returns to 0. A period is MOD+1 steps and the counter never exceeds MOD.
- R4: With global control bit 3 set, the counter climbs to MOD and then descends to 0, one step at a time. A period is 2×MOD steps.
- R5: An unpaired channel is active while the counter is below its compare value. A compare value of 0 is never active. A compare value of MOD+1 or more is active for the whole period.
- R6: Channel control bits [1:0] are the mode and bits [3:2] are the level. The pin drives PWM only when the mode is 2 and the level is nonzero. Level bit 3 set gives high-true output, and level 01 gives low-true output. Any other setting holds the pin at 0.
- R7: A channel control write appears in read-back one clock after the write cycle. A nonzero write is discarded when the working control field is already nonzero.
- R8: Modulo and compare writes take effect only on the step where the counter goes to 0. The period in progress completes with the old values.
- R9: When pair p is joined, pin 2p is active while the counter is at or above compare 2p and below compare 2p+1, using the control of channel 2p. Pin 2p+1 is held at 0.
- R10: While global control bit 4 is set, every pin is 0.
- R11: In up-only counting with PS = 0 and compare 1, the pin is active on exactly counter value 0. This holds already in the first period after the compare is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | CW | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | CW | Read data (combinational) |
| count | output | CW | Current counter value |
| pwm_out | output | NCH | Channel pins |

## Verification
Two situations are the hardest to create from the ports: a shadow register written in the middle of a period, and a compare of 1 that loads on the very reload where it must first act. The bench waits on the counter port for a chosen value and then issues the write. Checks placed later in the same period confirm that the old value still applies, and checks at the next period's start confirm that the new one does. Randomised prescale, modulo, direction, pairing, polarity and compare values, including 0 and MOD+1 or more, are each checked over whole periods.

// File: rtl/pwm_timer.sv
module pwm_timer #(
  parameter int NCH    = 4,
  parameter int CW     = 16,
  parameter int ADDR_W = $clog2(4 + 2 * NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CW-1:0]     rd_data,
  output logic [CW-1:0]     count,
  output logic [NCH-1:0]    pwm_out
);
  localparam int NPAIR = NCH / 2;
  localparam int PSW   = 3;
  localparam int PREW  = (1 << PSW) - 1;

  logic [PSW-1:0]   ps;
  logic             center, decode_en, up;
  logic [NPAIR-1:0] pair_en;
  logic [CW-1:0]    mod_buf, mod_act, cnt, nxt;
  logic [PREW-1:0]  pre;
  logic [PREW:0]    pmask;
  logic             tick, up_nxt, reload;

  logic [CW-1:0] cv_buf  [NCH];
  logic [CW-1:0] cv_act  [NCH];
  logic [3:0]    ctl     [NCH];
  logic [3:0]    ctl_req [NCH];
  logic [NCH-1:0] req_v;

  assign pmask  = ({{PREW{1'b0}}, 1'b1} << ps) - {{PREW{1'b0}}, 1'b1};
  assign tick   = (pre & pmask[PREW-1:0]) == pmask[PREW-1:0];
  assign reload = tick && (nxt == '0);
  assign count  = cnt;

  always_comb begin
    if (!center)              nxt = (cnt >= mod_act) ? '0 : cnt + 1'b1;
    else if (mod_act == '0)   nxt = '0;
    else if (up)              nxt = (cnt >= mod_act) ? cnt - 1'b1 : cnt + 1'b1;
    else                      nxt = (cnt == '0) ? cnt + 1'b1 : cnt - 1'b1;
    if (!center)  up_nxt = 1'b1;
    else if (up)  up_nxt = !(cnt >= mod_act);
    else          up_nxt = (cnt <= CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0; cnt <= '0; up <= 1'b1; mod_act <= '0;
    end else begin
      pre <= pre + 1'b1;
      if (tick) begin
        cnt <= nxt;
        up  <= up_nxt;
        if (reload) mod_act <= mod_buf;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps <= '0; center <= 1'b0; decode_en <= 1'b0; mod_buf <= '0; pair_en <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(0)) begin
        ps        <= wr_data[PSW-1:0];
        center    <= wr_data[3];
        decode_en <= wr_data[4];
      end
      if (wr_addr == ADDR_W'(1)) mod_buf <= wr_data;
      if (wr_addr == ADDR_W'(2)) pair_en <= wr_data[NPAIR-1:0];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic act, en;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl[i] <= '0; ctl_req[i] <= '0; req_v[i] <= 1'b0;
        cv_buf[i] <= '0; cv_act[i] <= '0;
      end else begin
        req_v[i] <= 1'b0;
        if (req_v[i] && (ctl_req[i] == '0 || ctl[i] == '0)) ctl[i] <= ctl_req[i];
        if (wr_en && wr_addr == ADDR_W'(4 + 2 * i)) begin
          ctl_req[i] <= wr_data[3:0];
          req_v[i]   <= 1'b1;
        end
        if (wr_en && wr_addr == ADDR_W'(5 + 2 * i)) cv_buf[i] <= wr_data;
        if (reload) cv_act[i] <= cv_buf[i];
      end
    end

    if (i % 2 == 0) begin : g_even
      assign act = pair_en[i/2] ? (cnt >= cv_act[i] && cnt < cv_act[i+1]) : (cnt < cv_act[i]);
      assign en  = ctl[i][1:0] == 2'd2 && ctl[i][3:2] != 2'd0 && !decode_en;
    end else begin : g_odd
      assign act = cnt < cv_act[i];
      assign en  = ctl[i][1:0] == 2'd2 && ctl[i][3:2] != 2'd0 && !decode_en && !pair_en[i/2];
    end

    assign pwm_out[i] = en && (ctl[i][3] ? act : !act);
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(0)) rd_data = {{(CW-PSW-2){1'b0}}, decode_en, center, ps};
    if (rd_addr == ADDR_W'(1)) rd_data = mod_buf;
    if (rd_addr == ADDR_W'(2)) rd_data = {{(CW-NPAIR){1'b0}}, pair_en};
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr == ADDR_W'(4 + 2 * i)) rd_data = {{(CW-4){1'b0}}, ctl[i]};
      if (rd_addr == ADDR_W'(5 + 2 * i)) rd_data = cv_buf[i];
    end
  end
endmodule

module pwm_timer_props #(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic           center,
  input logic           up,
  input logic           decode_en,
  input logic [CW-1:0]  cnt,
  input logic [CW-1:0]  mod_act,
  input logic [NCH-1:0] pwm_out,
  input logic [3:0]     ctl0,
  input logic [3:0]     req0,
  input logic           rv0
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  assert_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= mod_act);

  assert_edge_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!center && tick && cnt >= mod_act) |=> cnt == '0);

  assert_center_turn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (center && tick && up && mod_act != '0 && cnt >= mod_act) |=> (cnt == $past(cnt) - 1'b1 && !up));

  assert_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rv0 && req0 != 4'd0 && ctl0 != 4'd0) |=> $stable(ctl0));

  assert_decode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    decode_en |-> pwm_out == '0);
endmodule

bind pwm_timer pwm_timer_props #(.NCH(NCH), .CW(CW)) u_props (
  .clk(clk), .rst_n(rst_n), .tick(tick), .center(center), .up(up),
  .decode_en(decode_en), .cnt(cnt), .mod_act(mod_act), .pwm_out(pwm_out),
  .ctl0(ctl[0]), .req0(ctl_req[0]), .rv0(req_v[0])
);

// File: tb/pwm_timer_bench.sv
`timescale 1ns/1ps
module pwm_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [15:0] count;
  logic [3:0]  pwm_out;

  int total = 0;
  int bad = 0;

  int       b_ps = 0, b_mod = 0;
  bit       b_center = 0, b_dec = 0;
  bit [1:0] b_pair = 0;
  bit [3:0] b_ctl [4];
  int       b_cv  [4];

  pwm_timer u_pwm_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .count(count), .pwm_out(pwm_out)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[3:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = a[3:0];
    #1;
    v = int'(rd_data);
  endtask

  function automatic bit exp_pin(input int ch, input int c);
    bit act;
    bit [3:0] k;
    k = b_ctl[ch];
    if (b_dec) return 0;
    if (b_pair[ch/2]) begin
      if (ch % 2 == 1) return 0;
      act = (c >= b_cv[ch]) && (c < b_cv[ch+1]);
    end else begin
      act = c < b_cv[ch];
    end
    if (k[1:0] != 2'd2 || k[3:2] == 2'd0) return 0;
    return k[3] ? act : !act;
  endfunction

  function automatic bit [3:0] exp_vec(input int c);
    bit [3:0] e;
    for (int ch = 0; ch < 4; ch++) e[ch] = exp_pin(ch, c);
    return e;
  endfunction

  task automatic set_ch(input int ch, input bit [3:0] k, input int cv);
    int v;
    wr(4 + 2 * ch, 0);
    rd(4 + 2 * ch, v);
    for (int t = 0; t < 10 && v != 0; t++) begin @(negedge clk); rd(4 + 2 * ch, v); end
    wr(4 + 2 * ch, int'(k));
    rd(4 + 2 * ch, v);
    for (int t = 0; t < 10 && v == 0 && k != 0; t++) begin @(negedge clk); rd(4 + 2 * ch, v); end
    wr(5 + 2 * ch, cv);
    b_ctl[ch] = k;
    b_cv[ch] = cv;
  endtask

  task automatic set_glob(input int ps, input bit cen, input bit dec);
    wr(0, (int'(dec) << 4) | (int'(cen) << 3) | ps);
    b_ps = ps; b_center = cen; b_dec = dec;
  endtask

  task automatic wait_cnt(input int v);
    for (int t = 0; t < 2000; t++) begin
      @(negedge clk);
      if (int'(count) == v) return;
    end
    chk(0, "wait for counter value", int'(count), v);
  endtask

  task automatic mon(input int n, input string tag);
    int prev = -1, gap = 0, c;
    bit seen = 0;
    bit [3:0] e;
    for (int s = 0; s < n; s++) begin
      @(negedge clk);
      c = int'(count);
      e = exp_vec(c);
      chk(pwm_out == e, tag, int'(pwm_out), int'(e));
      gap++;
      if (prev >= 0 && c != prev) begin
        if (b_center)
          chk((c == prev + 1 || c == prev - 1) && c <= b_mod, "R4 center step", c, prev);
        else
          chk(c == ((prev >= b_mod) ? 0 : prev + 1), "R3 edge step", c, (prev >= b_mod) ? 0 : prev + 1);
        if (seen) chk(gap == (1 << b_ps), "R2 step spacing", gap, 1 << b_ps);
        seen = 1;
        gap = 0;
      end
      prev = c;
    end
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, z0, z1;
    void'($urandom(32'd4711));
    for (int ch = 0; ch < 4; ch++) begin b_ctl[ch] = 0; b_cv[ch] = 0; end
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(count == 0, "R1 counter", int'(count), 0);
    chk(pwm_out == 0, "R1 pins", int'(pwm_out), 0);
    rd(0, v); chk(v == 0, "R1 global control", v, 0);
    rd(4, v); chk(v == 0, "R1 channel control", v, 0);
    rst_n = 1'b1;

    // R5 R6: directed edge-mode corner compare values
    set_glob(0, 0, 0);
    wr(1, 9); b_mod = 9;
    set_ch(0, 4'b1010, 3);
    set_ch(1, 4'b0110, 0);
    set_ch(2, 4'b1010, 10);
    set_ch(3, 4'b1001, 5);
    repeat (30) @(negedge clk);
    mon(40, "R5 R6 directed edge");

    // random configurations
    for (int it = 0; it < 10; it++) begin
      int m;
      set_glob($urandom_range(0, 2), 1'($urandom_range(0, 1)), 0);
      m = $urandom_range(3, 40);
      wr(1, m); b_mod = m;
      b_pair = 2'($urandom_range(0, 3));
      wr(2, int'(b_pair));
      for (int ch = 0; ch < 4; ch++) begin
        bit [3:0] k;
        k[3:2] = ($urandom_range(0, 1) == 1) ? 2'b10 : 2'b01;
        k[1:0] = ($urandom_range(0, 3) == 0) ? 2'd1 : 2'd2;
        set_ch(ch, k, $urandom_range(0, m + 2));
      end
      repeat ((4 * 64 + 8) << b_ps) @(negedge clk);
      mon((2 * b_mod + 2) * 2 << b_ps, "R5 R6 R9 random");
    end

    // R4 center period is 2*MOD
    b_pair = 0; wr(2, 0);
    set_glob(0, 1, 0);
    wr(1, 5); b_mod = 5;
    repeat (60) @(negedge clk);
    wait_cnt(0); z0 = 0;
    @(negedge clk);
    for (int t = 1; t < 100; t++) begin
      if (count == 0) begin z1 = t; break; end
      @(negedge clk);
    end
    chk(z1 == 10, "R4 center period", z1, 10);

    // R8 buffered compare and modulo
    set_glob(0, 0, 0);
    wr(1, 19); b_mod = 19;
    set_ch(0, 4'b1010, 8);
    repeat (60) @(negedge clk);
    wait_cnt(5);
    wr(5, 15);
    wait_cnt(10);
    chk(pwm_out[0] == 1'b0, "R8 old compare kept", int'(pwm_out[0]), 0);
    wait_cnt(0);
    wait_cnt(10);
    chk(pwm_out[0] == 1'b1, "R8 new compare at next period", int'(pwm_out[0]), 1);
    wait_cnt(5);
    wr(1, 29);
    wait_cnt(19);
    @(negedge clk);
    chk(count == 0, "R8 old modulo wraps", int'(count), 0);
    wait_cnt(29);
    chk(count == 29, "R8 new modulo reached", int'(count), 29);
    b_mod = 29; b_cv[0] = 15;

    // R7 control handshake
    wr(4, 4'b0110);
    rd(4, v); chk(v == 4'b1010, "R7 readback lag", v, 4'b1010);
    @(negedge clk);
    rd(4, v); chk(v == 4'b1010, "R7 nonzero over nonzero ignored", v, 4'b1010);
    wr(4, 0);
    rd(4, v); chk(v == 4'b1010, "R7 clear lag", v, 4'b1010);
    @(negedge clk);
    rd(4, v); chk(v == 0, "R7 clear acknowledged", v, 0);
    chk(pwm_out[0] == 1'b0, "R6 disabled pin", int'(pwm_out[0]), 0);
    wr(4, 4'b0110);
    @(negedge clk);
    rd(4, v); chk(v == 4'b0110, "R7 new mode accepted", v, 4'b0110);
    set_ch(0, 4'b1010, 15);

    // R9 combined pair
    wr(1, 19); b_mod = 19;
    b_pair = 2'b01; wr(2, 1);
    set_ch(0, 4'b1010, 4);
    set_ch(1, 4'b1010, 12);
    repeat (80) @(negedge clk);
    mon(60, "R9 combined");

    // R10 decode hold
    b_pair = 0; wr(2, 0);
    set_ch(1, 4'b0110, 0);
    repeat (50) @(negedge clk);
    chk(pwm_out[1] == 1'b1, "R6 low-true idle level", int'(pwm_out[1]), 1);
    set_glob(0, 0, 1);
    mon(30, "R10 decode hold");
    set_glob(0, 0, 0);

    // R11 compare of 1 with PS = 0
    wr(1, 7); b_mod = 7;
    set_ch(0, 4'b1010, 5);
    repeat (40) @(negedge clk);
    wait_cnt(3);
    wr(5, 1);
    wait_cnt(0);
    chk(pwm_out[0] == 1'b1, "R11 active at zero on first reload", int'(pwm_out[0]), 1);
    @(negedge clk);
    chk(count == 1, "R11 counter step", int'(count), 1);
    chk(pwm_out[0] == 1'b0, "R11 inactive at one", int'(pwm_out[0]), 0);
    b_cv[0] = 1;
    mon(32, "R11 steady");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule